// File: doc/BRIEF.md
# SIMT Control-Flow Mask Sequencer

This block steps through a control-flow program on behalf of one wavefront of 64 lanes that share a single program counter. It holds one execution-mask bit per lane and three private stacks: saved masks for divergent branches, loop records for nested counted loops, and return addresses for subroutine calls. The program is read one 64-bit word per cycle. The block presents its program counter on `pc_o`, and the surrounding logic returns the word at that address on `instr_i`, together with a per-lane condition vector on `pred_i`, in the same cycle.

Branch divergence is handled entirely through the mask. A lane whose bit is clear takes no part in work that is dispatched. A jump is taken only when the whole wavefront is idle, so a branch body that no lane would run is skipped. Work clauses (arithmetic, texture fetch or vertex fetch) are not executed here. The block raises a request that carries the clause address and the current mask, and it holds until the executing unit reports completion.

A program starts from address 0 when `start_i` is pulsed while the block is not busy. It runs until an end word, a return with no caller, or a stack error.

Top module: `cfseq_top`

## Requirements
- R1: After reset the block is idle, with busy, done, error and clause request all low and with PC 0 and mask 0. A `start_i` pulse while not busy gives, at the next edge, busy high, PC 0, the mask equal to `init_mask_i`, error cleared and all stacks emptied.
- R2: Instruction fields are as follows. The opcode sits in bits [63:59], the branch or clause target in bits [ADDR_W-1:0], the loop count in bits [16+CNT_W-1:16] and the clause kind in bits [57:56]. The opcodes are 0 NOP, 1 END, 2 PUSH, 3 POP, 4 ELSE, 5 JUMP, 6 LOOP_BEGIN, 7 LOOP_END, 8 LOOP_BREAK, 9 LOOP_CONT, 10 CALL, 11 RETURN and 12 CLAUSE. Any other code acts as NOP. NOP advances the PC by one and leaves the mask unchanged.
- R3: PUSH saves the mask on an 8-deep mask stack and sets mask = mask & pred. POP restores the saved mask and removes it from the stack. A push onto a full stack, or a POP or ELSE on an empty stack, sets the error flag and halts.
- R4: ELSE sets mask = saved & ~mask, where "saved" is the saved mask on top of the stack, and leaves that stack entry in place.
- R5: JUMP loads its target into the PC only when every mask bit is zero. Otherwise the PC advances by one.
- R6: LOOP_BEGIN with a count of zero, or with an all-zero mask, jumps to its target and records no loop. Otherwise it records the count, PC+1 and the entry mask on a 4-deep loop stack, and advances.
- R7: LOOP_END decrements the count. If the count is still nonzero and the next mask (entry & ~broken lanes) is nonzero, the PC returns to the first word of the loop body and the mask becomes that next mask. Otherwise the loop record is removed, the mask returns to the entry mask and the PC advances. Loop-stack overflow or underflow sets the error flag.
- R8: LOOP_BREAK clears active lanes whose predicate is set, and keeps them cleared for the remaining iterations. LOOP_CONT clears them only until the next iteration begins.
- R9: CALL saves PC+1 on a 4-deep return stack and jumps to its target. A fifth nested CALL sets the error flag. RETURN resumes at the saved address. RETURN with an empty stack halts without error.
- R10: CLAUSE raises the clause request together with the target address, the kind and the current mask. It holds the request and the PC until `clause_done_i` is seen high; the PC is the next address one cycle later.
- R11: END halts with done high. While halted, the PC and mask hold and the program words are ignored. The error flag stays set until the next start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Begin a program at address 0 |
| init_mask_i | input | 64 | Lane mask loaded at start |
| instr_i | input | 64 | Program word at `pc_o` |
| pred_i | input | 64 | Per-lane condition for the current word |
| clause_done_i | input | 1 | Completion of the outstanding clause |
| pc_o | output | ADDR_W | Program counter |
| exec_mask_o | output | 64 | Current per-lane execution mask |
| clause_valid_o | output | 1 | Clause request pending |
| clause_kind_o | output | 2 | Clause kind field |
| clause_addr_o | output | ADDR_W | Clause start address |
| clause_mask_o | output | 64 | Lanes the clause runs for |
| busy_o | output | 1 | Program running or waiting on a clause |
| done_o | output | 1 | Sequencer halted |
| error_o | output | 1 | Sticky stack fault |

## Verification
The properties assume that `instr_i` and `pred_i` are combinational functions of `pc_o` that are stable for the whole cycle. They also assume that `clause_done_i` is raised only while a request is pending. The bench serves both from small arrays indexed by the PC. Its completion responder asserts done only in the negedge after it has seen a pending request, and drops done again one cycle later. Starts are issued only while the block is idle or halted, which is the only case for which the start property makes a claim.

// File: rtl/cfseq_pkg.sv
package cfseq_pkg;
   localparam int LANES = 64;
   localparam int WORD_W = 64;
   localparam int OP_LSB = 59;

   localparam logic [4:0] OP_NOP   = 5'd0;
   localparam logic [4:0] OP_END   = 5'd1;
   localparam logic [4:0] OP_PUSH  = 5'd2;
   localparam logic [4:0] OP_POP   = 5'd3;
   localparam logic [4:0] OP_ELSE  = 5'd4;
   localparam logic [4:0] OP_JUMP  = 5'd5;
   localparam logic [4:0] OP_LBEG  = 5'd6;
   localparam logic [4:0] OP_LEND  = 5'd7;
   localparam logic [4:0] OP_LBRK  = 5'd8;
   localparam logic [4:0] OP_LCONT = 5'd9;
   localparam logic [4:0] OP_CALL  = 5'd10;
   localparam logic [4:0] OP_RET   = 5'd11;
   localparam logic [4:0] OP_CLS   = 5'd12;

   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_RUN  = 2'd1,
      ST_WAIT = 2'd2,
      ST_HALT = 2'd3
   } seq_state_e;
endpackage

// File: rtl/cfseq_decode.sv
module cfseq_decode
   import cfseq_pkg::*;
#(
   parameter int ADDR_W = 10,
   parameter int CNT_W  = 16
) (
   input  logic [WORD_W-1:0] instr_i,
   output logic [4:0]        op_o,
   output logic [ADDR_W-1:0] target_o,
   output logic [CNT_W-1:0]  count_o,
   output logic [1:0]        kind_o
);
   if (ADDR_W < 1 || ADDR_W > 16) begin : g_bad_addr
      $error("cfseq_decode: ADDR_W must lie in 1..16");
   end
   if (CNT_W < 1 || CNT_W > 16) begin : g_bad_cnt
      $error("cfseq_decode: CNT_W must lie in 1..16");
   end

   logic unused_word;
   assign unused_word = ^instr_i;

   assign op_o     = instr_i[OP_LSB +: 5];
   assign target_o = instr_i[ADDR_W-1:0];
   assign count_o  = instr_i[16 +: CNT_W];
   assign kind_o   = instr_i[57:56];
endmodule

// File: rtl/cfseq_lifo.sv
module cfseq_lifo #(
   parameter int W     = 8,
   parameter int DEPTH = 4
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         clr,
   input  logic         push,
   input  logic         pop,
   input  logic         wr_top,
   input  logic [W-1:0] din,
   output logic [W-1:0] top,
   output logic         empty,
   output logic         full
);
   localparam int CW = $clog2(DEPTH + 1);

   if (DEPTH < 1) begin : g_bad_depth
      $error("cfseq_lifo: DEPTH must be at least 1");
   end

   logic [CW-1:0] cnt_q;

   assign empty = (cnt_q == '0);
   assign full  = (cnt_q == CW'(DEPTH));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (clr) begin
         cnt_q <= '0;
      end else if (push && !full) begin
         cnt_q <= cnt_q + 1'b1;
      end else if (pop && !empty) begin
         cnt_q <= cnt_q - 1'b1;
      end
   end

   if (DEPTH == 1) begin : g_single
      logic [W-1:0] ent_q;
      always_ff @(posedge clk) begin
         if ((push && !full) || (wr_top && !empty)) ent_q <= din;
      end
      assign top = empty ? '0 : ent_q;
   end else begin : g_array
      localparam int PW = $clog2(DEPTH);
      logic [W-1:0]  mem_q [DEPTH];
      logic [PW-1:0] top_idx;
      logic [PW-1:0] wr_idx;
      assign top_idx = PW'(cnt_q - 1'b1);
      assign wr_idx  = push ? PW'(cnt_q) : top_idx;
      always_ff @(posedge clk) begin
         if ((push && !full) || (wr_top && !empty)) mem_q[wr_idx] <= din;
      end
      assign top = empty ? '0 : mem_q[top_idx];
   end
endmodule

// File: rtl/cfseq_top.sv
module cfseq_top
   import cfseq_pkg::*;
#(
   parameter int ADDR_W     = 10,
   parameter int CNT_W      = 16,
   parameter int MASK_DEPTH = 8,
   parameter int LOOP_DEPTH = 4,
   parameter int CALL_DEPTH = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start_i,
   input  logic [LANES-1:0]  init_mask_i,
   input  logic [WORD_W-1:0] instr_i,
   input  logic [LANES-1:0]  pred_i,
   input  logic              clause_done_i,
   output logic [ADDR_W-1:0] pc_o,
   output logic [LANES-1:0]  exec_mask_o,
   output logic              clause_valid_o,
   output logic [1:0]        clause_kind_o,
   output logic [ADDR_W-1:0] clause_addr_o,
   output logic [LANES-1:0]  clause_mask_o,
   output logic              busy_o,
   output logic              done_o,
   output logic              error_o
);
   localparam int LREC_W = CNT_W + ADDR_W + 2 * LANES;

   if (MASK_DEPTH < 1 || LOOP_DEPTH < 1 || CALL_DEPTH < 1) begin : g_bad_depths
      $error("cfseq_top: every stack depth must be at least 1");
   end

   seq_state_e        st_q, st_n;
   logic [ADDR_W-1:0] pc_q, pc_n, pc_inc;
   logic [LANES-1:0]  mask_q, mask_n;
   logic              err_q, err_n;
   logic [1:0]        kind_q;
   logic [ADDR_W-1:0] caddr_q;

   logic [4:0]        op;
   logic [ADDR_W-1:0] tgt;
   logic [CNT_W-1:0]  cnt;
   logic [1:0]        kind;

   cfseq_decode #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_dec (
      .instr_i (instr_i),
      .op_o    (op),
      .target_o(tgt),
      .count_o (cnt),
      .kind_o  (kind)
   );

   // Stack control
   logic              clr;
   logic              ms_push, ms_pop, ms_empty, ms_full;
   logic [LANES-1:0]  ms_top;
   logic              ls_push, ls_pop, ls_wr, ls_empty, ls_full;
   logic [LREC_W-1:0] ls_din, ls_top;
   logic              rs_push, rs_pop, rs_empty, rs_full;
   logic [ADDR_W-1:0] rs_top;

   cfseq_lifo #(.W(LANES), .DEPTH(MASK_DEPTH)) u_mask_stk (
      .clk(clk), .rst_n(rst_n), .clr(clr), .push(ms_push), .pop(ms_pop),
      .wr_top(1'b0), .din(mask_q), .top(ms_top), .empty(ms_empty), .full(ms_full)
   );

   cfseq_lifo #(.W(LREC_W), .DEPTH(LOOP_DEPTH)) u_loop_stk (
      .clk(clk), .rst_n(rst_n), .clr(clr), .push(ls_push), .pop(ls_pop),
      .wr_top(ls_wr), .din(ls_din), .top(ls_top), .empty(ls_empty), .full(ls_full)
   );

   cfseq_lifo #(.W(ADDR_W), .DEPTH(CALL_DEPTH)) u_ret_stk (
      .clk(clk), .rst_n(rst_n), .clr(clr), .push(rs_push), .pop(rs_pop),
      .wr_top(1'b0), .din(pc_inc), .top(rs_top), .empty(rs_empty), .full(rs_full)
   );

   // Loop record fields: count, body start, entry mask, broken lanes
   logic [CNT_W-1:0]  l_cnt, l_cnt_dec;
   logic [ADDR_W-1:0] l_start;
   logic [LANES-1:0]  l_entry, l_brk, l_next;
   assign {l_cnt, l_start, l_entry, l_brk} = ls_top;
   assign l_cnt_dec = l_cnt - 1'b1;
   assign l_next    = l_entry & ~l_brk;
   assign pc_inc    = pc_q + 1'b1;

   always_comb begin
      st_n    = st_q;
      pc_n    = pc_q;
      mask_n  = mask_q;
      err_n   = err_q;
      clr     = 1'b0;
      ms_push = 1'b0;
      ms_pop  = 1'b0;
      ls_push = 1'b0;
      ls_pop  = 1'b0;
      ls_wr   = 1'b0;
      ls_din  = '0;
      rs_push = 1'b0;
      rs_pop  = 1'b0;
      unique case (st_q)
         ST_IDLE, ST_HALT: begin
            if (start_i) begin
               st_n   = ST_RUN;
               pc_n   = '0;
               mask_n = init_mask_i;
               err_n  = 1'b0;
               clr    = 1'b1;
            end
         end
         ST_WAIT: begin
            if (clause_done_i) begin
               st_n = ST_RUN;
               pc_n = pc_inc;
            end
         end
         default: begin
            pc_n = pc_inc;
            case (op)
               OP_END: begin
                  st_n = ST_HALT;
                  pc_n = pc_q;
               end
               OP_PUSH: begin
                  if (ms_full) begin
                     err_n = 1'b1;
                  end else begin
                     ms_push = 1'b1;
                     mask_n  = mask_q & pred_i;
                  end
               end
               OP_POP: begin
                  if (ms_empty) begin
                     err_n = 1'b1;
                  end else begin
                     ms_pop = 1'b1;
                     mask_n = ms_top;
                  end
               end
               OP_ELSE: begin
                  if (ms_empty) err_n = 1'b1;
                  else mask_n = ms_top & ~mask_q;
               end
               OP_JUMP: begin
                  if (mask_q == '0) pc_n = tgt;
               end
               OP_LBEG: begin
                  if (cnt == '0 || mask_q == '0) begin
                     pc_n = tgt;
                  end else if (ls_full) begin
                     err_n = 1'b1;
                  end else begin
                     ls_push = 1'b1;
                     ls_din  = {cnt, pc_inc, mask_q, {LANES{1'b0}}};
                  end
               end
               OP_LEND: begin
                  if (ls_empty) begin
                     err_n = 1'b1;
                  end else if (l_cnt_dec == '0 || l_next == '0) begin
                     ls_pop = 1'b1;
                     mask_n = l_entry;
                  end else begin
                     ls_wr  = 1'b1;
                     ls_din = {l_cnt_dec, l_start, l_entry, l_brk};
                     pc_n   = l_start;
                     mask_n = l_next;
                  end
               end
               OP_LBRK: begin
                  if (ls_empty) begin
                     err_n = 1'b1;
                  end else begin
                     ls_wr  = 1'b1;
                     ls_din = {l_cnt, l_start, l_entry, l_brk | (mask_q & pred_i)};
                     mask_n = mask_q & ~pred_i;
                  end
               end
               OP_LCONT: begin
                  if (ls_empty) err_n = 1'b1;
                  else mask_n = mask_q & ~pred_i;
               end
               OP_CALL: begin
                  if (rs_full) begin
                     err_n = 1'b1;
                  end else begin
                     rs_push = 1'b1;
                     pc_n    = tgt;
                  end
               end
               OP_RET: begin
                  if (rs_empty) begin
                     st_n = ST_HALT;
                     pc_n = pc_q;
                  end else begin
                     rs_pop = 1'b1;
                     pc_n   = rs_top;
                  end
               end
               OP_CLS: begin
                  st_n = ST_WAIT;
                  pc_n = pc_q;
               end
               default: ;
            endcase
            if (err_n && !err_q) begin
               st_n   = ST_HALT;
               pc_n   = pc_q;
               mask_n = mask_q;
            end
         end
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q    <= ST_IDLE;
         pc_q    <= '0;
         mask_q  <= '0;
         err_q   <= 1'b0;
         kind_q  <= '0;
         caddr_q <= '0;
      end else begin
         st_q   <= st_n;
         pc_q   <= pc_n;
         mask_q <= mask_n;
         err_q  <= err_n;
         if (st_q == ST_RUN && op == OP_CLS) begin
            kind_q  <= kind;
            caddr_q <= tgt;
         end
      end
   end

   assign pc_o           = pc_q;
   assign exec_mask_o    = mask_q;
   assign clause_valid_o = (st_q == ST_WAIT);
   assign clause_kind_o  = kind_q;
   assign clause_addr_o  = caddr_q;
   assign clause_mask_o  = mask_q;
   assign busy_o         = (st_q == ST_RUN) || (st_q == ST_WAIT);
   assign done_o         = (st_q == ST_HALT);
   assign error_o        = err_q;
endmodule

// File: rtl/cfseq_checker.sv
module cfseq_checker
   import cfseq_pkg::*;
#(
   parameter int ADDR_W = 10
) (
   input logic              clk,
   input logic              rst_n,
   input logic              start_i,
   input logic [LANES-1:0]  init_mask_i,
   input logic [WORD_W-1:0] instr_i,
   input logic [LANES-1:0]  pred_i,
   input logic              clause_done_i,
   input logic [ADDR_W-1:0] pc_o,
   input logic [LANES-1:0]  exec_mask_o,
   input logic              clause_valid_o,
   input logic [ADDR_W-1:0] clause_addr_o,
   input logic [LANES-1:0]  clause_mask_o,
   input logic              busy_o,
   input logic              done_o,
   input logic              error_o
);
   logic              stepping;
   logic [4:0]        opc;
   logic [ADDR_W-1:0] pc_next;
   assign stepping = busy_o && !clause_valid_o;
   assign opc      = instr_i[OP_LSB +: 5];
   assign pc_next  = pc_o + 1'b1;

   p_start_r1: assert property (@(posedge clk) disable iff (!rst_n)
      start_i && !busy_o |=> busy_o && pc_o == '0 && !error_o
                             && exec_mask_o == $past(init_mask_i));

   p_push_and_r3: assert property (@(posedge clk) disable iff (!rst_n)
      stepping && opc == OP_PUSH |=>
         error_o || exec_mask_o == ($past(exec_mask_o) & $past(pred_i)));

   p_jump_fall_r5: assert property (@(posedge clk) disable iff (!rst_n)
      stepping && opc == OP_JUMP && exec_mask_o != '0 |=> pc_o == $past(pc_next));

   p_clause_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
      clause_valid_o && !clause_done_i |=> clause_valid_o && $stable(pc_o)
         && $stable(clause_addr_o) && $stable(clause_mask_o));

   p_clause_adv_r10: assert property (@(posedge clk) disable iff (!rst_n)
      clause_valid_o && clause_done_i |=> !clause_valid_o && pc_o == $past(pc_next));

   p_halt_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
      done_o && !start_i |=> done_o && $stable(pc_o) && $stable(exec_mask_o));

   p_err_sticky_r11: assert property (@(posedge clk) disable iff (!rst_n)
      error_o && !start_i |=> error_o);
endmodule

bind cfseq_top cfseq_checker #(.ADDR_W(ADDR_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .start_i(start_i), .init_mask_i(init_mask_i),
   .instr_i(instr_i), .pred_i(pred_i), .clause_done_i(clause_done_i),
   .pc_o(pc_o), .exec_mask_o(exec_mask_o), .clause_valid_o(clause_valid_o),
   .clause_addr_o(clause_addr_o), .clause_mask_o(clause_mask_o),
   .busy_o(busy_o), .done_o(done_o), .error_o(error_o)
);

// File: tb/cfseq_top_tb.sv
`timescale 1ns/1ps
module cfseq_top_tb;
   localparam int AW = 10;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          start = 1'b0;
   logic [63:0]   init_mask = '0;
   logic [63:0]   instr, pred;
   logic          clause_done;
   logic [AW-1:0] pc;
   logic [63:0]   emask, cmask;
   logic          cvalid, busy, done, err;
   logic [1:0]    ckind;
   logic [AW-1:0] caddr;

   logic [63:0] prog  [32];
   logic [63:0] predm [32];
   assign instr = prog[pc[4:0]];
   assign pred  = predm[pc[4:0]];

   logic auto_ack = 1'b1, auto_done = 1'b0, man_ack = 1'b0;
   assign clause_done = auto_ack ? auto_done : man_ack;

   int checks = 0, fails = 0;
   bit finished = 1'b0;
   logic [63:0]   log_mask [16];
   logic [AW-1:0] log_addr [16];
   int log_n = 0;

   always #4 clk = ~clk;

   cfseq_top u_dut (
      .clk(clk), .rst_n(rst_n), .start_i(start), .init_mask_i(init_mask),
      .instr_i(instr), .pred_i(pred), .clause_done_i(clause_done),
      .pc_o(pc), .exec_mask_o(emask), .clause_valid_o(cvalid),
      .clause_kind_o(ckind), .clause_addr_o(caddr), .clause_mask_o(cmask),
      .busy_o(busy), .done_o(done), .error_o(err)
   );

   function automatic logic [63:0] mk(input int op, input int cnt, input int tgt, input int kd);
      mk = (64'(op) << 59) | (64'(kd & 3) << 56) | (64'(cnt & 16'hFFFF) << 16) | 64'(tgt & 10'h3FF);
   endfunction

   task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic clear_prog();
      for (int i = 0; i < 32; i++) begin
         prog[i]  = mk(1, 0, 0, 0);
         predm[i] = '0;
      end
   endtask

   task automatic run_prog(input logic [63:0] m);
      log_n = 0;
      @(negedge clk); start = 1'b1; init_mask = m;
      @(negedge clk); start = 1'b0;
      for (int i = 0; i < 400 && !done; i++) @(negedge clk);
   endtask

   // Clause completion responder: completes each request after a short wait and logs it
   initial begin
      int wcnt = 0;
      forever begin
         @(negedge clk);
         if (auto_ack && cvalid && !auto_done) begin
            if (wcnt == 2) begin
               log_mask[log_n[3:0]] = cmask;
               log_addr[log_n[3:0]] = caddr;
               log_n++;
               auto_done = 1'b1;
               wcnt = 0;
            end else wcnt++;
         end else auto_done = 1'b0;
      end
   end

   typedef struct packed {
      logic [63:0]   ins;
      logic [63:0]   prd;
      logic [63:0]   init;
      logic [63:0]   emask;
      logic [AW-1:0] epc;
      logic          edone;
   } vec_t;

   localparam vec_t VECS [9] = '{
      '{mk(0, 0, 0, 0),  64'h0,  64'hF0, 64'hF0, 10'd1,  1'b0},  // R2 NOP
      '{mk(2, 0, 0, 0),  64'h3C, 64'hF0, 64'h30, 10'd1,  1'b0},  // R3 PUSH ands pred
      '{mk(5, 0, 7, 0),  64'h0,  64'h0,  64'h0,  10'd7,  1'b0},  // R5 jump taken
      '{mk(5, 0, 7, 0),  64'h0,  64'h1,  64'h1,  10'd1,  1'b0},  // R5 jump not taken
      '{mk(6, 0, 9, 0),  64'h0,  64'hFF, 64'hFF, 10'd9,  1'b0},  // R6 zero count
      '{mk(6, 2, 9, 0),  64'h0,  64'h0,  64'h0,  10'd9,  1'b0},  // R6 empty mask
      '{mk(6, 2, 9, 0),  64'h0,  64'hA,  64'hA,  10'd1,  1'b0},  // R6 enter loop
      '{mk(10, 0, 12, 0), 64'h0, 64'h3,  64'h3,  10'd12, 1'b0},  // R9 call
      '{mk(1, 0, 0, 0),  64'h0,  64'h3,  64'h3,  10'd0,  1'b1}   // R11 end
   };

   initial begin
      repeat (150000) @(posedge clk);
      if (!finished) begin
         fails++;
         checks++;
         $display("FAIL watchdog actual=%h expected=%h", 64'(0), 64'(1));
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end

   initial begin
      clear_prog();
      repeat (3) @(negedge clk);
      // R1 reset state
      chk(!busy && !done && !err && !cvalid && pc == '0 && emask == '0, "R1 reset",
          {busy, done, err, cvalid, 54'(pc), 6'(0)} | emask, 64'(0));
      rst_n = 1'b1;
      @(negedge clk);

      // Single-step vectors
      foreach (VECS[k]) begin
         clear_prog();
         prog[0]  = VECS[k].ins;
         predm[0] = VECS[k].prd;
         @(negedge clk); start = 1'b1; init_mask = VECS[k].init;
         @(negedge clk); start = 1'b0;
         if (k == 0) chk(busy && pc == '0 && emask == 64'hF0 && !err, "R1 start", emask, 64'hF0);
         @(negedge clk);
         chk(pc == VECS[k].epc, $sformatf("R2 vector %0d pc", k), 64'(pc), 64'(VECS[k].epc));
         chk(emask == VECS[k].emask, $sformatf("R3 vector %0d mask", k), emask, VECS[k].emask);
         chk(done == VECS[k].edone, $sformatf("R11 vector %0d done", k), 64'(done), 64'(VECS[k].edone));
         for (int i = 0; i < 40 && !done; i++) @(negedge clk);
      end

      // R3 R4 if/else/endif
      clear_prog();
      prog[0] = mk(2, 0, 0, 0); predm[0] = 64'h0000_0000_0000_FFFF;
      prog[1] = mk(12, 0, 1, 0);
      prog[2] = mk(4, 0, 0, 0);
      prog[3] = mk(12, 0, 3, 0);
      prog[4] = mk(3, 0, 0, 0);
      prog[5] = mk(12, 0, 5, 0);
      run_prog('1);
      chk(log_n == 3, "R4 clause count", 64'(log_n), 64'd3);
      chk(log_mask[0] == 64'h0000_0000_0000_FFFF, "R3 then mask", log_mask[0], 64'h0000_0000_0000_FFFF);
      chk(log_mask[1] == 64'hFFFF_FFFF_FFFF_0000, "R4 else mask", log_mask[1], 64'hFFFF_FFFF_FFFF_0000);
      chk(log_mask[2] == '1 && emask == '1, "R3 pop restores", log_mask[2], '1);

      // R5 skip a body no lane runs
      clear_prog();
      prog[0] = mk(2, 0, 0, 0); predm[0] = 64'hF0;
      prog[1] = mk(5, 0, 3, 0);
      prog[2] = mk(12, 0, 2, 0);
      prog[3] = mk(3, 0, 0, 0);
      prog[4] = mk(12, 0, 4, 0);
      run_prog(64'hF);
      chk(log_n == 1 && log_addr[0] == 10'd4, "R5 body skipped", 64'(log_addr[0]), 64'd4);
      chk(log_mask[0] == 64'hF, "R5 mask after skip", log_mask[0], 64'hF);

      // R7 R8 three-iteration loop with break and continue
      clear_prog();
      prog[0] = mk(6, 3, 6, 0);
      prog[1] = mk(12, 0, 1, 0);
      prog[2] = mk(8, 0, 0, 0); predm[2] = 64'h01;
      prog[3] = mk(9, 0, 0, 0); predm[3] = 64'h02;
      prog[4] = mk(12, 0, 4, 0);
      prog[5] = mk(7, 0, 0, 0);
      prog[6] = mk(12, 0, 6, 0);
      run_prog(64'hFF);
      begin
         logic [63:0] expm [7] = '{64'hFF, 64'hFC, 64'hFE, 64'hFC, 64'hFE, 64'hFC, 64'hFF};
         chk(log_n == 7, "R7 iteration count", 64'(log_n), 64'd7);
         for (int i = 0; i < 7; i++)
            chk(log_mask[i] == expm[i], $sformatf("R8 loop mask %0d", i), log_mask[i], expm[i]);
      end

      // R7 early exit when every lane has broken out
      clear_prog();
      prog[0] = mk(6, 5, 4, 0);
      prog[1] = mk(8, 0, 0, 0); predm[1] = 64'h3;
      prog[2] = mk(12, 0, 2, 0);
      prog[3] = mk(7, 0, 0, 0);
      prog[4] = mk(12, 0, 4, 0);
      run_prog(64'h3);
      chk(log_n == 2 && log_mask[0] == '0, "R7 early exit body", log_mask[0], 64'h0);
      chk(log_addr[1] == 10'd4 && log_mask[1] == 64'h3, "R7 exit restores entry", log_mask[1], 64'h3);

      // R9 call and return, then return with no caller ends the program
      clear_prog();
      prog[0] = mk(10, 0, 4, 0);
      prog[1] = mk(12, 0, 1, 0);
      prog[2] = mk(11, 0, 0, 0);
      prog[4] = mk(12, 0, 4, 0);
      prog[5] = mk(11, 0, 0, 0);
      run_prog(64'h5);
      chk(log_n == 2 && log_addr[0] == 10'd4 && log_addr[1] == 10'd1, "R9 call order",
          64'(log_addr[1]), 64'd1);
      chk(done && !err && pc == 10'd2, "R9 empty return halts", 64'(pc), 64'd2);

      // R9 return stack overflow
      clear_prog();
      for (int i = 0; i < 5; i++) prog[i] = mk(10, 0, i + 1, 0);
      run_prog(64'h1);
      chk(done && err, "R9 call overflow", 64'(err), 64'd1);

      // R3 mask stack overflow and underflow
      clear_prog();
      for (int i = 0; i < 9; i++) begin prog[i] = mk(2, 0, 0, 0); predm[i] = '1; end
      run_prog(64'h1);
      chk(done && err && pc == 10'd8, "R3 push overflow", 64'(pc), 64'd8);
      repeat (3) @(negedge clk);
      chk(err, "R11 error sticky", 64'(err), 64'd1);
      clear_prog();
      prog[0] = mk(3, 0, 0, 0);
      @(negedge clk); start = 1'b1; init_mask = 64'h1;
      @(negedge clk); start = 1'b0;
      chk(!err, "R1 start clears error", 64'(err), 64'd0);
      @(negedge clk);
      chk(err && done, "R3 pop underflow", 64'(err), 64'd1);

      // R7 loop end without loop
      clear_prog();
      prog[0] = mk(7, 0, 0, 0);
      run_prog(64'h1);
      chk(err, "R7 loop underflow", 64'(err), 64'd1);

      // R10 clause handshake under manual control
      clear_prog();
      auto_ack = 1'b0;
      prog[0] = mk(12, 0, 9, 2);
      @(negedge clk); start = 1'b1; init_mask = 64'h55;
      @(negedge clk); start = 1'b0;
      @(negedge clk);
      chk(cvalid && caddr == 10'd9 && ckind == 2'd2 && cmask == 64'h55, "R10 request fields",
          {caddr, ckind, 52'(0)}, {10'd9, 2'd2, 52'(0)});
      repeat (3) @(negedge clk);
      chk(cvalid && pc == '0, "R10 hold while pending", 64'(pc), 64'd0);
      man_ack = 1'b1;
      @(negedge clk); man_ack = 1'b0;
      chk(!cvalid && pc == 10'd1, "R10 advance after done", 64'(pc), 64'd1);
      @(negedge clk);
      chk(done && pc == 10'd1, "R11 end halts", 64'(pc), 64'd1);
      prog[1] = mk(0, 0, 0, 0);
      repeat (4) @(negedge clk);
      chk(done && pc == 10'd1 && emask == 64'h55, "R11 halted ignores words", 64'(pc), 64'd1);
      auto_ack = 1'b1;

      finished = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end
endmodule